// File: doc/BRIEF.md
# Command-Queue I2C Bus Master

This block is an I2C bus master that is driven only by queued command words. Software pushes 10-bit words into a command queue. Each word carries one byte plus two flags: one opens a transfer or reopens it with a repeated START, and the other closes it with a STOP. The controller turns each word into bus activity on open-drain clock and data lines. It sends an address after each START, sends data bytes for writes, and clocks in data bytes for reads. Every byte read is paced by its own placeholder word in the command queue. Received bytes go into a receive queue.

The controller handles acknowledge on its own. It checks the slave's ACK after an address or a written byte. On a read, it ACKs each received byte, or NACKs it when the placeholder word carries the STOP flag. When it runs out of commands, or when the receive queue has no room, it holds the clock low, so software can feed and drain the queues at its own pace. The clock low and high times come from a divider input. Each high phase starts only once the clock line is actually seen high, so a slave can stretch the clock.

Top module: `i2cq_master`

## Requirements
- R1: After reset both queues are empty with level 0, both line enables are off (lines released), busy is 0 and the error flag is 0.
- R2: A command word uses bits [7:0] as the byte, bit 8 as the START request and bit 9 as the STOP request. A word with bit 8 set produces a START (a repeated START if the bus is already held), followed by that byte sent MSB first as the slave address. The address byte's bit 0 selects the direction: 0 for write, 1 for read.
- R3: In a write transfer, each later word is sent MSB first and the slave's ACK is sampled in the ninth clock. A word with bit 9 set is followed by a STOP after its ACK.
- R4: A word without bit 8 that reaches the controller while the bus is idle is dropped, and the lines stay released.
- R5: In a read transfer, each later word yields exactly one received byte, and its byte value is ignored. The received bytes enter the receive queue in bus order.
- R6: For a received byte whose word lacks bit 9, the master drives ACK (data low). For a received byte whose word has bit 9, it leaves NACK (data high) and then issues a STOP.
- R7: A received byte is stored in the receive queue at the end of its eighth clock, before the acknowledge clock, so it can be read while the clock is held.
- R8: If storing a byte fills the receive queue, the clock is held low before that byte's acknowledge clock until an entry is popped. The receive-full flag is high while the queue is full.
- R9: In a write transfer, if the command queue is empty after an acknowledge clock, the clock is held low until a word is pushed.
- R10: In a read transfer, if a received byte's word lacks bit 9 and the command queue is empty, the clock is held low between the eighth clock and the acknowledge clock until a word is pushed.
- R11: A NACK on an address or a written byte sets a sticky error flag and ends the transfer with a STOP. The flag stays set until the clear input is pulsed.
- R12: Each queue holds 8 entries and reports full, empty and level. A push into a full queue is ignored, and so is a pop from an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | 16 | Bus clock low and high phase length in cycles (at least 1) |
| cmd_data | input | 10 | Command word to push |
| cmd_push | input | 1 | Push cmd_data into the command queue |
| cmd_full | output | 1 | Command queue full |
| cmd_empty | output | 1 | Command queue empty |
| cmd_level | output | 4 | Command queue entry count |
| rx_data | output | 8 | Oldest received byte |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | 4 | Receive queue entry count |
| rx_full_irq | output | 1 | Receive-full interrupt flag |
| nack_err | output | 1 | Sticky flag for an unacknowledged address or written byte |
| nack_clr | input | 1 | Clears nack_err |
| busy | output | 1 | A transfer is in progress |
| scl_oe | output | 1 | Pull the clock line low |
| scl_in | input | 1 | Sampled clock line |
| sda_oe | output | 1 | Pull the data line low |
| sda_in | input | 1 | Sampled data line |

## Verification
Two events can land in the same cycle. One is software pushing a command word while the sequencer pops the head of the same queue. The other is software popping the receive queue while the clock stall on a full queue is released. The bench drives a burst of consecutive pushes into an idle controller, so the first pop meets the second push. It then checks that every byte reaches the bus slave model in the original order. It also fills the receive queue, queues further placeholder words, and drains the queue one entry at a time while the sequencer refills it. It judges the result by the complete ordered list of 16 received bytes and by the acknowledge pattern the slave model records.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int CMD_W     = 10;
  localparam int BYTE_W    = 8;
  localparam int START_POS = 8;
  localparam int STOP_POS  = 9;

  typedef enum logic [3:0] {
    S_IDLE, S_ST_HOLD, S_ST_LO, S_BIT_LO, S_BIT_HI, S_RWAIT, S_ACK_LO,
    S_ACK_HI, S_FETCH, S_RS_LO, S_RS_HI, S_SP_LO, S_SP_HI, S_SP_END
  } seq_state_e;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full  = (cnt == LW'(DEPTH));
  assign empty = (cnt == '0);
  assign level = cnt;
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rp];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_wr && !do_rd)      cnt <= cnt + 1'b1;
      else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
    end
  end

  assert_level_cap_R12: assert property (@(posedge clk) disable iff (rst)
    cnt <= LW'(DEPTH));
  assert_push_full_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (wr && !rd && full) |=> (cnt == $past(cnt)));
  assert_pop_empty_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr && empty) |=> (cnt == '0));
endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
  import i2cq_pkg::*;
#(
  parameter int DIVW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIVW-1:0]   div,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              cmd_empty,
  output logic              cmd_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_byte,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              err_clr,
  output logic              nack_err,
  output logic              busy
);
  seq_state_e        st;
  logic [DIVW-1:0]   cnt;
  logic [BYTE_W-1:0] sh;
  logic [2:0]        bitn;
  logic              rd_mode, is_addr, stop_req;
  logic              adv, rd_data, hi_done;

  assign adv     = (cnt >= div);
  assign rd_data = rd_mode && !is_addr;
  assign hi_done = scl_in && adv;
  assign busy    = (st != S_IDLE);
  assign cmd_pop = ((st == S_IDLE) || (st == S_FETCH)) && !cmd_empty;
  assign rx_push = (st == S_BIT_HI) && hi_done && (bitn == 3'd7) && rd_data;
  assign rx_byte = {sh[BYTE_W-2:0], sda_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      bitn     <= '0;
      rd_mode  <= 1'b0;
      is_addr  <= 1'b0;
      stop_req <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      nack_err <= 1'b0;
    end else begin
      if (err_clr) nack_err <= 1'b0;
      if (!adv) cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          if (!cmd_empty && cmd_word[START_POS]) begin
            stop_req <= cmd_word[STOP_POS];
            sh       <= cmd_word[BYTE_W-1:0];
            sda_oe   <= 1'b1;
            cnt      <= '0;
            st       <= S_ST_HOLD;
          end
        end
        S_ST_HOLD: if (adv) begin
          scl_oe <= 1'b1;
          cnt    <= '0;
          st     <= S_ST_LO;
        end
        S_ST_LO: if (adv) begin
          rd_mode <= sh[0];
          is_addr <= 1'b1;
          bitn    <= '0;
          sda_oe  <= ~sh[BYTE_W-1];
          cnt     <= '0;
          st      <= S_BIT_LO;
        end
        S_BIT_LO: if (adv) begin
          scl_oe <= 1'b0;
          cnt    <= '0;
          st     <= S_BIT_HI;
        end
        S_BIT_HI: begin
          if (!scl_in) cnt <= '0;
          else if (adv) begin
            sh     <= {sh[BYTE_W-2:0], sda_in};
            scl_oe <= 1'b1;
            cnt    <= '0;
            bitn   <= bitn + 1'b1;
            if (bitn == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= rd_data ? S_RWAIT : S_ACK_LO;
            end else begin
              sda_oe <= rd_data ? 1'b0 : ~sh[BYTE_W-2];
              st     <= S_BIT_LO;
            end
          end
        end
        S_RWAIT: if (!rx_full && (stop_req || !cmd_empty)) begin
          sda_oe <= ~stop_req;
          cnt    <= '0;
          st     <= S_ACK_LO;
        end
        S_ACK_LO: if (adv) begin
          scl_oe <= 1'b0;
          cnt    <= '0;
          st     <= S_ACK_HI;
        end
        S_ACK_HI: begin
          if (!scl_in) cnt <= '0;
          else if (adv) begin
            scl_oe <= 1'b1;
            cnt    <= '0;
            if (!rd_data && sda_in) begin
              nack_err <= 1'b1;
              sda_oe   <= 1'b1;
              st       <= S_SP_LO;
            end else if (stop_req) begin
              sda_oe <= 1'b1;
              st     <= S_SP_LO;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_FETCH;
            end
          end
        end
        S_FETCH: if (!cmd_empty) begin
          stop_req <= cmd_word[STOP_POS];
          sh       <= cmd_word[BYTE_W-1:0];
          cnt      <= '0;
          if (cmd_word[START_POS]) begin
            sda_oe <= 1'b0;
            st     <= S_RS_LO;
          end else begin
            is_addr <= 1'b0;
            bitn    <= '0;
            sda_oe  <= rd_mode ? 1'b0 : ~cmd_word[BYTE_W-1];
            st      <= S_BIT_LO;
          end
        end
        S_RS_LO: if (adv) begin
          scl_oe <= 1'b0;
          cnt    <= '0;
          st     <= S_RS_HI;
        end
        S_RS_HI: begin
          if (!scl_in) cnt <= '0;
          else if (adv) begin
            sda_oe <= 1'b1;
            cnt    <= '0;
            st     <= S_ST_HOLD;
          end
        end
        S_SP_LO: if (adv) begin
          scl_oe <= 1'b0;
          cnt    <= '0;
          st     <= S_SP_HI;
        end
        S_SP_HI: begin
          if (!scl_in) cnt <= '0;
          else if (adv) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_SP_END;
          end
        end
        S_SP_END: if (adv) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // data line quiet while the clock is high inside a bit or ack slot
  assert_sda_quiet_high_R2: assert property (@(posedge clk) disable iff (rst)
    ((st == S_BIT_HI || st == S_ACK_HI) && $past(st) == st && !scl_oe && !$past(scl_oe))
      |-> $stable(sda_oe));
  assert_no_push_when_full_R8: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !rx_full);
  assert_hold_on_rx_full_R8: assert property (@(posedge clk) disable iff (rst)
    (st == S_RWAIT && rx_full) |=> (st == S_RWAIT && scl_oe));
  assert_hold_on_cmd_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH && cmd_empty) |=> (st == S_FETCH && scl_oe));
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (nack_err && !err_clr) |=> nack_err);
endmodule

// File: rtl/i2cq_master.sv
module i2cq_master
  import i2cq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIVW  = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIVW-1:0]   clk_div,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              cmd_push,
  output logic              cmd_full,
  output logic              cmd_empty,
  output logic [LW-1:0]     cmd_level,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              rx_pop,
  output logic              rx_full,
  output logic              rx_empty,
  output logic [LW-1:0]     rx_level,
  output logic              rx_full_irq,
  output logic              nack_err,
  input  logic              nack_clr,
  output logic              busy,
  output logic              scl_oe,
  input  logic              scl_in,
  output logic              sda_oe,
  input  logic              sda_in
);
  logic [CMD_W-1:0]  head;
  logic              pop_cmd, push_rx;
  logic [BYTE_W-1:0] rx_wbyte;

  i2cq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmdq (
    .clk(clk), .rst(rst), .wr(cmd_push), .wdata(cmd_data), .rd(pop_cmd),
    .rdata(head), .full(cmd_full), .empty(cmd_empty), .level(cmd_level)
  );

  i2cq_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .wr(push_rx), .wdata(rx_wbyte), .rd(rx_pop),
    .rdata(rx_data), .full(rx_full), .empty(rx_empty), .level(rx_level)
  );

  i2cq_seq #(.DIVW(DIVW)) u_seq (
    .clk(clk), .rst(rst), .div(clk_div),
    .cmd_word(head), .cmd_empty(cmd_empty), .cmd_pop(pop_cmd),
    .rx_full(rx_full), .rx_push(push_rx), .rx_byte(rx_wbyte),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .err_clr(nack_clr), .nack_err(nack_err), .busy(busy)
  );

  assign rx_full_irq = rx_full;
endmodule

// File: tb/sim_i2cq_master.sv
module sim_i2cq_master;
  logic       clk = 1'b0;
  logic       rst;
  logic [15:0] clk_div;
  logic [9:0] cmd_data;
  logic       cmd_push, rx_pop, nack_clr;
  logic       cmd_full, cmd_empty, rx_full, rx_empty, rx_full_irq, nack_err, busy;
  logic [3:0] cmd_level, rx_level;
  logic [7:0] rx_data;
  logic       scl_oe, sda_oe, s_oe;
  logic       scl_line, sda_line;

  always #2 clk = ~clk;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || s_oe);

  i2cq_master u0 (
    .clk(clk), .rst(rst), .clk_div(clk_div), .cmd_data(cmd_data), .cmd_push(cmd_push),
    .cmd_full(cmd_full), .cmd_empty(cmd_empty), .cmd_level(cmd_level),
    .rx_data(rx_data), .rx_pop(rx_pop), .rx_full(rx_full), .rx_empty(rx_empty),
    .rx_level(rx_level), .rx_full_irq(rx_full_irq), .nack_err(nack_err),
    .nack_clr(nack_clr), .busy(busy), .scl_oe(scl_oe), .scl_in(scl_line),
    .sda_oe(sda_oe), .sda_in(sda_line)
  );

  // ---------------- bus slave model, address 0x52 ----------------
  localparam logic [6:0] SL_ADDR = 7'h52;
  logic       ps, pd, s_on, saddr, s_tx, s_rw, s_lack;
  logic [3:0] sc;
  logic [7:0] ssh, txsh, tx_idx;
  logic [7:0] wlog [32];
  logic       mack [32];
  int         wn, mack_n;

  always @(posedge clk) begin
    if (rst) begin
      ps <= 1'b1; pd <= 1'b1; s_on <= 1'b0; saddr <= 1'b0; s_tx <= 1'b0;
      s_rw <= 1'b0; s_lack <= 1'b1; sc <= '0; ssh <= '0; txsh <= '0;
      tx_idx <= '0; s_oe <= 1'b0; wn <= 0; mack_n <= 0;
    end else begin
      ps <= scl_line;
      pd <= sda_line;
      if (ps && scl_line && pd && !sda_line) begin
        sc <= '0; saddr <= 1'b1; s_on <= 1'b1; s_tx <= 1'b0; s_oe <= 1'b0; tx_idx <= '0;
      end else if (ps && scl_line && !pd && sda_line) begin
        s_on <= 1'b0; s_oe <= 1'b0; s_tx <= 1'b0;
      end else if (s_on) begin
        if (!ps && scl_line) begin
          if (sc < 8 && !s_tx) ssh <= {ssh[6:0], sda_line};
          if (sc == 8 && s_tx) begin
            mack[mack_n] <= sda_line;
            mack_n <= mack_n + 1;
            s_lack <= sda_line;
          end
          sc <= sc + 1'b1;
        end else if (ps && !scl_line) begin
          if (sc == 8) begin
            if (s_tx) s_oe <= 1'b0;
            else if (saddr) begin
              if (ssh[7:1] == SL_ADDR) begin
                s_oe <= 1'b1; wlog[wn] <= ssh; wn <= wn + 1; s_rw <= ssh[0];
              end else s_on <= 1'b0;
            end else begin
              s_oe <= 1'b1; wlog[wn] <= ssh; wn <= wn + 1;
            end
          end else if (sc == 9) begin
            sc <= '0; saddr <= 1'b0;
            if ((saddr && s_rw) || (s_tx && !s_lack)) begin
              s_tx   <= 1'b1;
              s_oe   <= ~(8'hA0 + tx_idx) >> 7;
              txsh   <= (8'hA0 + tx_idx) << 1;
              tx_idx <= tx_idx + 1'b1;
            end else begin
              s_tx <= 1'b0; s_oe <= 1'b0;
            end
          end else if (s_tx && sc >= 1 && sc < 8) begin
            s_oe <= ~txsh[7];
            txsh <= {txsh[6:0], 1'b0};
          end
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] w);
    @(negedge clk);
    while (cmd_full) @(negedge clk);
    cmd_data = w; cmd_push = 1'b1;
    @(negedge clk);
    cmd_push = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    @(negedge clk);
    b = rx_data; rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 30000; k++) begin
      @(negedge clk);
      if (!busy && cmd_empty) break;
    end
    repeat (4) @(negedge clk);
  endtask

  // write vectors: {command word, byte the slave must log}
  localparam logic [17:0] WR_TAB [4] = '{
    {10'h1A4, 8'hA4}, {10'h03C, 8'h3C}, {10'h0FF, 8'hFF}, {10'h281, 8'h81}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [7:0] rb [16];
    int base, mb, got;
    rst = 1'b1; clk_div = 16'd4; cmd_data = '0; cmd_push = 1'b0; rx_pop = 1'b0; nack_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_empty && rx_empty && cmd_level == 0 && rx_level == 0, "R1 queues", {cmd_level, rx_level}, 0);
    chk(!scl_oe && !sda_oe && !busy && !nack_err, "R1 lines", {scl_oe, sda_oe, busy, nack_err}, 0);

    // table walk: burst push (push meets first pop in one cycle)
    base = wn;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cmd_data = WR_TAB[i][17:8]; cmd_push = 1'b1;
    end
    @(negedge clk); cmd_push = 1'b0;
    wait_idle();
    chk(wn == base + 4, "R3 byte count", wn - base, 4);
    for (int i = 0; i < 4; i++)
      chk(wlog[base + i] == WR_TAB[i][7:0], (i == 0) ? "R2 address" : "R3 data",
          wlog[base + i], WR_TAB[i][7:0]);
    chk(!nack_err && rx_empty && sda_line && scl_line, "R3 clean stop", nack_err, 0);

    // R9 write stall with empty queue
    base = wn;
    push(10'h1A4); push(10'h011);
    repeat (400) @(negedge clk);
    chk(!scl_line && busy && wn == base + 2, "R9 clock held low", {scl_line, busy}, 1);
    push(10'h222);
    wait_idle();
    chk(wn == base + 3 && wlog[base + 2] == 8'h22, "R9 resumed", wlog[base + 2], 8'h22);

    // R4 word without start at idle
    base = wn;
    push(10'h055);
    repeat (30) @(negedge clk);
    chk(cmd_empty && !busy && wn == base && scl_line && sda_line, "R4 dropped", {cmd_empty, busy}, 2);

    // R5/R6 read of three bytes
    mb = mack_n;
    push(10'h1A5); push(10'h000); push(10'h0FF); push(10'h27E);
    wait_idle();
    chk(rx_level == 3, "R5 level", rx_level, 3);
    for (int i = 0; i < 3; i++) begin
      pop(b);
      chk(b == 8'hA0 + i, "R5 read byte", b, 8'hA0 + i);
    end
    chk(mack_n == mb + 3, "R6 ack count", mack_n - mb, 3);
    chk(mack[mb] == 0 && mack[mb + 1] == 0 && mack[mb + 2] == 1, "R6 ack pattern",
        {mack[mb], mack[mb + 1], mack[mb + 2]}, 3'b001);

    // R7/R10 read stall before the ack slot
    mb = mack_n;
    push(10'h1A5); push(10'h0AA);
    repeat (400) @(negedge clk);
    chk(!scl_line && busy && mack_n == mb, "R10 held before ack", {scl_line, mack_n - mb}, 0);
    chk(rx_level == 1 && rx_data == 8'hA0, "R7 stored before ack", rx_data, 8'hA0);
    pop(b);
    push(10'h200);
    wait_idle();
    pop(b);
    chk(b == 8'hA1 && mack[mb] == 0 && mack[mb + 1] == 1, "R10 resumed", b, 8'hA1);

    // R8/R12 receive queue fills
    mb = mack_n;
    push(10'h1A5);
    for (int i = 0; i < 8; i++) push(10'h000);
    for (int k = 0; k < 5000 && !rx_full; k++) @(negedge clk);
    repeat (200) @(negedge clk);
    chk(rx_full && rx_full_irq && !scl_line, "R8 stall on full", {rx_full, rx_full_irq, scl_line}, 6);
    chk(mack_n == mb + 7, "R8 eighth ack pending", mack_n - mb, 7);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      cmd_data = (i == 7) ? 10'h200 : ((i == 8) ? 10'h0AA : 10'h000); cmd_push = 1'b1;
    end
    @(negedge clk); cmd_push = 1'b0;
    chk(cmd_full && cmd_level == 8, "R12 push on full ignored", cmd_level, 8);
    got = 0;
    for (int k = 0; k < 40000 && got < 16; k++) begin
      @(negedge clk);
      if (rx_pop) rx_pop = 1'b0;
      else if (!rx_empty) begin
        rb[got] = rx_data; got++; rx_pop = 1'b1;
      end
    end
    rx_pop = 1'b0;
    wait_idle();
    chk(got == 16, "R8 byte total", got, 16);
    for (int i = 0; i < 16; i++)
      if (i < got) chk(rb[i] == 8'hA0 + i, "R8 order", rb[i], 8'hA0 + i);
    chk(mack[mb + 15] == 1 && mack[mb + 14] == 0, "R6 final nack", mack[mb + 15], 1);
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    chk(rx_empty && rx_level == 0, "R12 pop on empty ignored", rx_level, 0);

    // R11 address not acknowledged
    base = wn;
    push(10'h1B0); push(10'h233);
    wait_idle();
    chk(nack_err && wn == base && cmd_empty && sda_line, "R11 error set", nack_err, 1);
    repeat (50) @(negedge clk);
    chk(nack_err, "R11 sticky", nack_err, 1);
    nack_clr = 1'b1;
    @(negedge clk); nack_clr = 1'b0;
    @(negedge clk);
    chk(!nack_err, "R11 cleared", nack_err, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule